// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block is the command interpreter of a 256K x 16 parallel NOR-style flash model. It sees the chip-select, write-strobe and output-enable lines (all active low) after they have been synchronised into the local clock, together with the address and data buses. It turns strobe overlaps into bus writes. It follows the protected unlock sequences that come before word-program, sector-erase, block-erase and chip-erase. When a command is accepted it holds a busy period of a set number of clock cycles, and during that period reads return status bits instead of array data.

The array is modelled sparsely. Every word reads as all ones unless it has been programmed since the last erase that covered it. A small table of programmed words holds the contents, so the whole 18-bit address space can be checked without storing 256K words. Erase commands remove table entries by sector, by block, or all at once.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A bus write is the interval in which ce_ni and we_ni are both low. Its address is addr_i at the first clock at which both are seen low. Its data is data_i at the first clock at which either is seen high again.
- R2: Word program is four writes: 16'h00AA at 18'h05555, 16'h0055 at 18'h02AAA, 16'h00A0 at 18'h05555, then the target address and data. The target word becomes its old value AND the written data.
- R3: Sector erase is six writes: 16'h00AA at 18'h05555, 16'h0055 at 18'h02AAA, 16'h0080 at 18'h05555, 16'h00AA at 18'h05555, 16'h0055 at 18'h02AAA, then 16'h0030 at any address. Every word whose address bits 17:11 equal those of that address then reads 16'hFFFF, and other words keep their values.
- R4: Block erase is the R3 sequence with 16'h0050 in the last write. It clears every word whose address bits 17:15 match those of the last write's address.
- R5: Chip erase is the R3 sequence with 16'h0010 at 18'h05555 in the last write, and it sets every word to 16'hFFFF. If 16'h0010 is written at any other address, nothing is launched.
- R6: While busy_o is high, every bus write is ignored. It does not change the array and does not advance any sequence.
- R7: busy_o rises on the second clock after the clock that sees the last write end. It stays high for exactly PROG_CYC cycles after a program, SECT_CYC cycles after a sector or block erase, and CHIP_CYC cycles after a chip erase.
- R8: A read during busy returns the status word. Bit 7 is the inverse of bit 7 of the programmed data (0 for any erase). Bit 6 inverts at the start of each new read access. All other bits are 0.
- R9: data_oe_o is high only while ce_ni and oe_ni are both low.
- R10: A write that is not the expected next step of a sequence returns the decoder to idle and leaves the array unchanged.
- R11: Programming never sets a bit: a 1 written over a stored 0 leaves 0.
- R12: At most N_SLOTS distinct addresses hold programmed data between erases. A program to a new address when the table is full is dropped, so that address reads 16'hFFFF; busy still runs.
- R13: After reset busy_o is 0, every word reads 16'hFFFF, and the sequence is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_ni | input | 1 | Chip select, active low, synchronised |
| we_ni | input | 1 | Write strobe, active low, synchronised |
| oe_ni | input | 1 | Output enable, active low, synchronised |
| addr_i | input | ADDR_W | Word address |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data or status |
| data_oe_o | output | 1 | Data output drive enable |
| busy_o | output | 1 | Internal program or erase running |

## Verification
The bench uses N_SLOTS = 8, PROG_CYC = 20, SECT_CYC = 40 and CHIP_CYC = 60. With busy periods this short, two status reads fit inside a program, and a whole four-write program sequence fits inside a chip erase, which tests that writes during busy are dropped. The eight-entry table fills during the random phase, so the rule that drops programs to new addresses when the table is full is exercised alongside sector and block erases over two blocks of two sectors.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERA1, S_ERA2, S_ERA3
  } seq_e;

  typedef enum logic [1:0] {OP_PROG, OP_SECT, OP_BLK, OP_CHIP} op_e;

  localparam logic [15:0] D_KEY1  = 16'h00AA;
  localparam logic [15:0] D_KEY2  = 16'h0055;
  localparam logic [15:0] D_PROG  = 16'h00A0;
  localparam logic [15:0] D_ERASE = 16'h0080;
  localparam logic [15:0] D_SECT  = 16'h0030;
  localparam logic [15:0] D_BLK   = 16'h0050;
  localparam logic [15:0] D_CHIP  = 16'h0010;
  localparam logic [14:0] A_KEY1  = 15'h5555;
  localparam logic [14:0] A_KEY2  = 15'h2AAA;
endpackage

// File: rtl/flash_bus_sampler.sv
module flash_bus_sampler #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_vld_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_start_o
);
  logic wr_act, wr_act_q, rd_act, rd_act_q;

  assign wr_act = ~ce_ni & ~we_ni;
  assign rd_act = ~ce_ni & ~oe_ni;
  assign rd_start_o = rd_act & ~rd_act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q  <= 1'b0;
      rd_act_q  <= 1'b0;
      wr_vld_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      wr_vld_o <= wr_act_q & ~wr_act;
      // address at the later falling strobe, data at the earlier rising one
      if (wr_act && !wr_act_q) wr_addr_o <= addr_i;
      if (!wr_act && wr_act_q) wr_data_o <= data_i;
    end
  end

  p_wr_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_vld_o |=> !wr_vld_o);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int PROG_CYC = 1400,
  parameter int SECT_CYC = 1800000,
  parameter int CHIP_CYC = 7000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_vld_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              op_go_o,
  output op_e               op_kind_o,
  output logic              busy_o,
  output logic              dq7_o
);
  localparam int MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int MAX_C = (MAX_A > CHIP_CYC) ? MAX_A : CHIP_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  seq_e st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic a_k1, a_k2, take;

  assign a_k1 = (wr_addr_i == ADDR_W'(A_KEY1));
  assign a_k2 = (wr_addr_i == ADDR_W'(A_KEY2));
  assign take = wr_vld_i & ~busy_o;

  always_comb begin
    st_d      = S_IDLE;
    op_go_o   = 1'b0;
    op_kind_o = OP_PROG;
    case (st_q)
      S_IDLE: if (a_k1 && wr_data_i == D_KEY1) st_d = S_UNL1;
      S_UNL1: if (a_k2 && wr_data_i == D_KEY2) st_d = S_UNL2;
      S_UNL2: begin
        if (a_k1 && wr_data_i == D_PROG)       st_d = S_PROG;
        else if (a_k1 && wr_data_i == D_ERASE) st_d = S_ERA1;
      end
      S_PROG: op_go_o = take;
      S_ERA1: if (a_k1 && wr_data_i == D_KEY1) st_d = S_ERA2;
      S_ERA2: if (a_k2 && wr_data_i == D_KEY2) st_d = S_ERA3;
      S_ERA3: begin
        if (wr_data_i == D_SECT) begin
          op_go_o = take; op_kind_o = OP_SECT;
        end else if (wr_data_i == D_BLK) begin
          op_go_o = take; op_kind_o = OP_BLK;
        end else if (a_k1 && wr_data_i == D_CHIP) begin
          op_go_o = take; op_kind_o = OP_CHIP;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      busy_o <= 1'b0;
      cnt_q  <= '0;
      dq7_o  <= 1'b0;
    end else begin
      if (busy_o)      st_q <= S_IDLE;
      else if (wr_vld_i) st_q <= st_d;
      if (op_go_o) begin
        busy_o <= 1'b1;
        case (op_kind_o)
          OP_PROG: cnt_q <= CW'(PROG_CYC - 1);
          OP_CHIP: cnt_q <= CW'(CHIP_CYC - 1);
          default: cnt_q <= CW'(SECT_CYC - 1);
        endcase
        dq7_o <= (op_kind_o == OP_PROG) ? ~wr_data_i[7] : 1'b0;
      end else if (busy_o) begin
        if (cnt_q == '0) busy_o <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
    end
  end

  p_launch_after_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(wr_vld_i));
  p_busy_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != '0) |=> busy_o);
  p_ignore_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(busy_o) && busy_o) |-> (st_q == S_IDLE));
endmodule

// File: rtl/flash_word_store.sv
module flash_word_store
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int N_SLOTS  = 8,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_go_i,
  input  op_e               op_kind_i,
  input  logic [ADDR_W-1:0] op_addr_i,
  input  logic [DATA_W-1:0] op_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int IW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  logic [N_SLOTS-1:0] vld_q;
  logic [ADDR_W-1:0]  sa_q [N_SLOTS];
  logic [DATA_W-1:0]  sd_q [N_SLOTS];
  logic          op_hit, free_any;
  logic [IW-1:0] op_idx, free_idx;
  logic [DATA_W-1:0] hit_dat;

  always_comb begin
    op_hit = 1'b0; op_idx = '0; free_any = 1'b0; free_idx = '0;
    rd_data_o = '1;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (vld_q[i] && sa_q[i] == op_addr_i) begin op_hit = 1'b1; op_idx = IW'(i); end
      if (!vld_q[i]) begin free_any = 1'b1; free_idx = IW'(i); end
      if (vld_q[i] && sa_q[i] == rd_addr_i) rd_data_o = sd_q[i];
    end
    hit_dat = sd_q[op_idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int i = 0; i < N_SLOTS; i++) begin sa_q[i] <= '0; sd_q[i] <= '0; end
    end else if (op_go_i) begin
      case (op_kind_i)
        OP_PROG: begin
          if (op_hit) sd_q[op_idx] <= sd_q[op_idx] & op_data_i;
          else if (free_any) begin
            vld_q[free_idx] <= 1'b1;
            sa_q[free_idx]  <= op_addr_i;
            sd_q[free_idx]  <= op_data_i;
          end
        end
        OP_SECT: for (int i = 0; i < N_SLOTS; i++)
          if (sa_q[i][ADDR_W-1:SECT_LSB] == op_addr_i[ADDR_W-1:SECT_LSB]) vld_q[i] <= 1'b0;
        OP_BLK: for (int i = 0; i < N_SLOTS; i++)
          if (sa_q[i][ADDR_W-1:BLK_LSB] == op_addr_i[ADDR_W-1:BLK_LSB]) vld_q[i] <= 1'b0;
        default: vld_q <= '0;
      endcase
    end
  end

  p_chip_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_go_i && op_kind_i == OP_CHIP) |=> (vld_q == '0));
  p_prog_no_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_go_i && op_kind_i == OP_PROG && op_hit) |=>
      ((sd_q[$past(op_idx)] & ~$past(hit_dat)) == '0));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int N_SLOTS  = 8,
  parameter int SECT_LSB = 11,
  parameter int BLK_LSB  = 15,
  parameter int PROG_CYC = 1400,
  parameter int SECT_CYC = 1800000,
  parameter int CHIP_CYC = 7000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_o
);
  logic              wr_vld, rd_start, op_go, dq7, tog_q;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, arr_data;
  op_e               op_kind;

  flash_bus_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_smp (
    .clk_i, .rst_ni, .ce_ni, .we_ni, .oe_ni, .addr_i, .data_i,
    .wr_vld_o(wr_vld), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_start_o(rd_start)
  );

  flash_seq_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .CHIP_CYC(CHIP_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .wr_vld_i(wr_vld), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .op_go_o(op_go), .op_kind_o(op_kind), .busy_o(busy_o), .dq7_o(dq7)
  );

  flash_word_store #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SLOTS(N_SLOTS),
    .SECT_LSB(SECT_LSB), .BLK_LSB(BLK_LSB)
  ) u_mem (
    .clk_i, .rst_ni, .op_go_i(op_go), .op_kind_i(op_kind),
    .op_addr_i(wr_addr), .op_data_i(wr_data),
    .rd_addr_i(addr_i), .rd_data_o(arr_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 tog_q <= 1'b0;
    else if (rd_start && busy_o) tog_q <= ~tog_q;
  end

  assign data_oe_o = ~ce_ni & ~oe_ni;
  assign data_o = busy_o ? {{(DATA_W-8){1'b0}}, dq7, tog_q, 6'b0} : arr_data;

  p_tog_stable_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(busy_o)) |-> $stable(tog_q));
endmodule

// File: tb/flash_cmd_decoder_bench.sv
module flash_cmd_decoder_bench;
  localparam int AW = 18, DW = 16, NS = 8;
  localparam int PC = 20, SC = 40, CC = 60;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, we_n = 1, oe_n = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, dout;
  logic doe, busy;

  int checks = 0, fails = 0, run = 0, last_run = 0, rises = 0;
  bit done = 0;
  logic busy_d = 0;
  logic [DW-1:0] mdl [int];

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .N_SLOTS(NS),
    .PROG_CYC(PC), .SECT_CYC(SC), .CHIP_CYC(CC)) u_flash_cmd_decoder (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .we_ni(we_n), .oe_ni(oe_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe), .busy_o(busy));

  always @(negedge clk) begin
    busy_d <= busy;
    if (busy && !busy_d) rises <= rises + 1;
    if (busy) run <= run + 1;
    else if (run != 0) begin last_run <= run; run <= 0; end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  function automatic logic [DW-1:0] exp_rd(int a);
    return mdl.exists(a) ? mdl[a] : 16'hFFFF;
  endfunction

  function automatic void m_prog(int a, logic [DW-1:0] d);
    if (mdl.exists(a)) mdl[a] = mdl[a] & d;
    else if (mdl.num() < NS) mdl[a] = d;
  endfunction

  function automatic void m_erase(int a, int lsb);
    int ks[$];
    foreach (mdl[k]) if ((k >> lsb) == (a >> lsb)) ks.push_back(k);
    foreach (ks[i]) mdl.delete(ks[i]);
  endfunction

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); addr = a; ce_n = 0;
    @(negedge clk); we_n = 0; din = d;
    repeat (2) @(negedge clk);
    we_n = 1;
    @(negedge clk); ce_n = 1;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0;
    repeat (2) @(negedge clk);
    d = dout;
    oe_n = 1; ce_n = 1;
  endtask

  task automatic unlock();
    wr(18'h05555, 16'h00AA); wr(18'h02AAA, 16'h0055);
  endtask
  task automatic cmd_prog(logic [AW-1:0] a, logic [DW-1:0] d);
    unlock(); wr(18'h05555, 16'h00A0); wr(a, d);
  endtask
  task automatic cmd_erase(logic [AW-1:0] a, logic [DW-1:0] c);
    unlock(); wr(18'h05555, 16'h0080); unlock(); wr(a, c);
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 200 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v, v2;
    int a, r0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R13 reset
    check("R13 busy", busy, 0);
    check("R13 oe", doe, 0);
    rst_n = 1;
    rd(18'h12345, v); check("R13 erased", v, 16'hFFFF);

    // R9 output enable
    @(negedge clk); ce_n = 0; oe_n = 1; @(negedge clk); check("R9 oe high", doe, 0);
    ce_n = 1; oe_n = 0; @(negedge clk); check("R9 ce high", doe, 0);
    ce_n = 0; @(negedge clk); check("R9 both low", doe, 1);
    ce_n = 1; oe_n = 1;

    // R2 / R7 program and busy length, R8 status
    cmd_prog(18'h00100, 16'h12B4); m_prog(32'h100, 16'h12B4);
    rd(18'h00100, v); rd(18'h00100, v2);
    check("R8 status bits", {v[15:7], v[5:0]}, {9'h000, 6'h00});
    check("R8 dq6 toggles", v[6] ^ v2[6], 1);
    wait_idle();
    check("R7 program busy", last_run, PC);
    rd(18'h00100, v); check("R2 program", v, exp_rd(32'h100));

    // R11 only clears
    cmd_prog(18'h00100, 16'hFF0F); m_prog(32'h100, 16'hFF0F); wait_idle();
    rd(18'h00100, v); check("R11 and", v, exp_rd(32'h100));

    // R1 skewed strobes: address at later fall, data at earlier rise
    unlock(); wr(18'h05555, 16'h00A0);
    @(negedge clk); addr = 18'h3FFFF; ce_n = 0;
    @(negedge clk); addr = 18'h00222;
    @(negedge clk); we_n = 0; din = 16'h5A5A;
    @(negedge clk); we_n = 1;
    @(negedge clk); din = 16'h0000; addr = 18'h3FFFF;
    @(negedge clk); ce_n = 1;
    m_prog(32'h222, 16'h5A5A); wait_idle();
    rd(18'h00222, v); check("R1 capture", v, 16'h5A5A);
    rd(18'h3FFFF, v); check("R1 other addr", v, 16'hFFFF);

    // R8 erase status dq7
    cmd_erase(18'h00800, 16'h0030); m_erase(32'h800, 11);
    rd(18'h00000, v); check("R8 erase dq7", v[7], 0);
    wait_idle(); check("R7 sector busy", last_run, SC);

    // R3 sector erase
    cmd_prog(18'h00900, 16'h0001); m_prog(32'h900, 16'h0001); wait_idle();
    cmd_erase(18'h00A00, 16'h0030); m_erase(32'hA00, 11); wait_idle();
    rd(18'h00900, v); check("R3 sector cleared", v, 16'hFFFF);
    rd(18'h00100, v); check("R3 other sector", v, exp_rd(32'h100));

    // R4 block erase
    cmd_prog(18'h08010, 16'h0002); m_prog(32'h8010, 16'h0002); wait_idle();
    cmd_erase(18'h07FFF, 16'h0050); m_erase(32'h7FFF, 15); wait_idle();
    rd(18'h00100, v); check("R4 block cleared", v, 16'hFFFF);
    rd(18'h08010, v); check("R4 other block", v, 16'h0002);

    // R5 chip erase wrong address does nothing
    r0 = rises;
    cmd_erase(18'h01234, 16'h0010); wait_idle();
    check("R5 no launch", rises, r0);
    rd(18'h08010, v); check("R5 kept", v, 16'h0002);

    // R5 chip erase, R6 writes during busy ignored
    cmd_erase(18'h05555, 16'h0010); mdl.delete();
    cmd_prog(18'h00444, 16'h0000);
    wait_idle();
    check("R7 chip busy", last_run, CC);
    rd(18'h08010, v); check("R5 chip cleared", v, 16'hFFFF);
    rd(18'h00444, v); check("R6 ignored prog", v, 16'hFFFF);
    r0 = rises;
    wr(18'h00444, 16'h0000); wait_idle();
    check("R6 no progress", rises, r0);

    // R10 mismatched step
    wr(18'h05555, 16'h00AA); wr(18'h05555, 16'h0055);
    wr(18'h02AAA, 16'h0055); wr(18'h05555, 16'h00A0); wr(18'h00555, 16'h0000);
    wait_idle();
    check("R10 no launch", rises, r0);
    rd(18'h00555, v); check("R10 array", v, 16'hFFFF);

    // R12 table capacity
    for (int i = 0; i <= NS; i++) begin
      cmd_prog(AW'(18'h10000 + i), 16'h0F0F); m_prog(32'h10000 + i, 16'h0F0F); wait_idle();
    end
    rd(AW'(18'h10000 + NS), v); check("R12 dropped", v, 16'hFFFF);
    rd(18'h10000, v); check("R12 kept", v, 16'h0F0F);
    cmd_erase(18'h05555, 16'h0010); mdl.delete(); wait_idle();

    // random mix against the model
    for (int n = 0; n < 60; n++) begin
      int sel = $urandom % 10;
      a = (($urandom % 2) << 15) | (($urandom % 2) << 11) | ($urandom % 4);
      if (sel < 7) begin
        v = 16'($urandom);
        cmd_prog(AW'(a), v); m_prog(a, v);
      end else if (sel < 9) begin
        cmd_erase(AW'(a), 16'h0030); m_erase(a, 11);
      end else begin
        cmd_erase(AW'(a), 16'h0050); m_erase(a, 15);
      end
      wait_idle();
      a = (($urandom % 2) << 15) | (($urandom % 2) << 11) | ($urandom % 4);
      rd(AW'(a), v);
      check(sel < 7 ? "R2 R12 random" : "R3 R4 random", v, exp_rd(a));
    end
    finish_run();
  end
endmodule